// File: doc/BRIEF.md
# Auto-Reload Timer with Byte-Overflow Flags

This block is a 16-bit up-counter built from a low byte and a high byte. When the full count passes its top value it does not fall to zero: it takes a preset start value from a 16-bit reload register and sets a sticky high overflow flag. Every time the low byte passes 0xFF it also sets a sticky low overflow flag. Each flag can drive a shared interrupt line, and each stays set until software writes it to zero.

Counting is paced by a one-cycle enable pulse. A select input chooses the source of that pulse: every system clock, one system clock in twelve, or one pulse per eight rising edges of an external clock. The external clock is asynchronous, so it is brought into the system clock domain before its edges are counted. A run input gates the pulse. A control bit switches to a split mode in which the two bytes count as separate 8-bit reloading timers. Software reaches the counter bytes, the reload bytes and a control byte through a simple byte-wide register port.

Top module: `autoReloadTimer`

## Requirements
- R1: After reset the counter bytes, reload bytes and control byte all read 0x00, and irq is low.
- R2: Register map on regAddr: 0 counter low byte, 1 counter high byte, 2 reload low byte, 3 reload high byte, 4 control byte. A write takes effect at the clock edge where regWrEn is high. The read data follows regAddr combinationally.
- R3: With clkSel = 0 and runEn high, the 16-bit count rises by one on every clock edge, and a carry passes from the low byte into the high byte.
- R4: In 16-bit mode, when the count is 0xFFFF and a count pulse arrives, the count becomes the reload value. Both the high flag (control bit 7) and the low flag (control bit 6) are set.
- R5: A low-byte wrap from 0xFF that is not a 16-bit overflow carries into the high byte and sets only the low flag.
- R6: While runEn is low, the counter holds its value.
- R7: With clkSel = 1, the counter advances exactly once in every 12 consecutive enabled clock edges.
- R8: With clkSel = 2, the counter advances once per 8 rising edges of the synchronized extClk. With clkSel = 3, it never advances.
- R9: A write to either counter byte in a cycle with a count pulse wins. That cycle has no increment, no carry and no reload.
- R10: Both flags stay set until a control write puts a zero in their bit. An overflow in the same cycle as such a write leaves the flag set.
- R11: irq equals control bit 0 (interrupt enable) AND (high flag OR (control bit 1, the low-byte interrupt enable, AND low flag)).
- R12: With control bit 2 set (split mode), each byte counts on its own. Each byte reloads from its own reload byte when it passes 0xFF. A low-byte wrap sets the low flag, and a high-byte wrap sets the high flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| runEn | input | 1 | Gates the count pulse |
| clkSel | input | 2 | Count source: 0 system clock, 1 divide by 12, 2 external divide by 8, 3 none |
| extClk | input | 1 | Asynchronous external clock |
| irq | output | 1 | Interrupt request |

## Verification
The corner cases are the wrap points, and the overflow at 0xFFFF is the main one. A design that reloads one cycle late, loads zero, or fails to set the low flag there would read back the wrong count or control byte. A counter write that lands on a count pulse must suppress that pulse. A design that lets both act would show a high byte already incremented. The prescalers are checked over whole windows of 12 and 8 source events: an off-by-one divider gains or loses ticks over the window. Split mode checks that the bytes reload from their own halves, which a design that still links the carry would miss.

// File: rtl/tmrPkg.sv
package tmrPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RLD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd4;

  localparam int BIT_INT_EN    = 0;
  localparam int BIT_LO_INT_EN = 1;
  localparam int BIT_SPLIT     = 2;
  localparam int BIT_LO_FLAG   = 6;
  localparam int BIT_HI_FLAG   = 7;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } clkSrcT;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              wrRldLo;
    logic              wrRldHi;
    logic              tick;
    logic              split;
    logic [BYTE_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/tmrPrescale.sv
module tmrPrescale #(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8,
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] clkSel,
  input  logic       extClk,
  output logic       tick
);
  import tmrPkg::*;

  localparam int SYS_W = $clog2(DIV_SYS);
  localparam int EXT_W = $clog2(DIV_EXT);

  logic [SYS_W-1:0] sysDiv;
  logic [EXT_W-1:0] extDiv;
  logic [SYNC_N:0]  extPipe;
  logic             extEdge;
  logic             srcPulse;

  // Synchronizer chain; the top stage holds the previous synchronized value
  assign extEdge = extPipe[SYNC_N-1] & ~extPipe[SYNC_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysDiv  <= '0;
      extDiv  <= '0;
      extPipe <= '0;
    end else begin
      extPipe <= {extPipe[SYNC_N-1:0], extClk};
      sysDiv  <= (sysDiv == SYS_W'(DIV_SYS-1)) ? '0 : sysDiv + SYS_W'(1);
      if (extEdge)
        extDiv <= (extDiv == EXT_W'(DIV_EXT-1)) ? '0 : extDiv + EXT_W'(1);
    end
  end

  always_comb begin
    unique case (clkSrcT'(clkSel))
      SRC_SYS: srcPulse = 1'b1;
      SRC_DIV: srcPulse = (sysDiv == SYS_W'(DIV_SYS-1));
      SRC_EXT: srcPulse = extEdge && (extDiv == EXT_W'(DIV_EXT-1));
      default: srcPulse = 1'b0;
    endcase
  end

  assign tick = runEn & srcPulse;

  // R7: divided system ticks never come back to back
  assert_div_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clkSel == 2'd1) |=> !(tick && clkSel == 2'd1));

  // R8: external ticks need fresh synchronized edges
  assert_ext_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clkSel == 2'd2) |=> !(tick && clkSel == 2'd2));
endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              tickIn,
  input  logic              wrapLo,
  input  logic              wrapHi,
  output strobeT            strobe,
  output logic [BYTE_W-1:0] ctrlByte,
  output logic              irq
);
  logic intEn, lowIntEn, splitMode, lowFlag, highFlag;
  logic wrCtrl;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  always_comb begin
    strobe.wrLo    = regWrEn && (regAddr == ADDR_CNT_LO);
    strobe.wrHi    = regWrEn && (regAddr == ADDR_CNT_HI);
    strobe.wrRldLo = regWrEn && (regAddr == ADDR_RLD_LO);
    strobe.wrRldHi = regWrEn && (regAddr == ADDR_RLD_HI);
    strobe.tick    = tickIn;
    strobe.split   = splitMode;
    strobe.data    = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn     <= 1'b0;
      lowIntEn  <= 1'b0;
      splitMode <= 1'b0;
      lowFlag   <= 1'b0;
      highFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        intEn     <= regWrData[BIT_INT_EN];
        lowIntEn  <= regWrData[BIT_LO_INT_EN];
        splitMode <= regWrData[BIT_SPLIT];
      end
      // Hardware set beats a software clear in the same cycle
      lowFlag  <= (wrCtrl ? regWrData[BIT_LO_FLAG] : lowFlag)  | wrapLo;
      highFlag <= (wrCtrl ? regWrData[BIT_HI_FLAG] : highFlag) | wrapHi;
    end
  end

  always_comb begin
    ctrlByte                = '0;
    ctrlByte[BIT_INT_EN]    = intEn;
    ctrlByte[BIT_LO_INT_EN] = lowIntEn;
    ctrlByte[BIT_SPLIT]     = splitMode;
    ctrlByte[BIT_LO_FLAG]   = lowFlag;
    ctrlByte[BIT_HI_FLAG]   = highFlag;
  end

  assign irq = intEn & (highFlag | (lowIntEn & lowFlag));

  // R10: an overflow always leaves its flag set, whatever software wrote
  assert_hi_flag_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrapHi |=> ctrlByte[BIT_HI_FLAG]);
  assert_lo_flag_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrapLo |=> ctrlByte[BIT_LO_FLAG]);
  // R10: flags are sticky without a control write
  assert_lo_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[BIT_LO_FLAG] && !wrCtrl) |=> ctrlByte[BIT_LO_FLAG]);
endmodule

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmrPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] reload,
  output logic                wrapLo,
  output logic                wrapHi
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] cntLo, cntHi, rldLo, rldHi;
  logic              wrCnt, step, loFull, hiFull;

  assign wrCnt  = strobe.wrLo | strobe.wrHi;
  assign step   = strobe.tick & ~wrCnt;
  assign loFull = &cntLo;
  assign hiFull = &cntHi;
  assign wrapLo = step & loFull;
  assign wrapHi = step & hiFull & (strobe.split | loFull);
  assign count  = {cntHi, cntLo};
  assign reload = {rldHi, rldLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
      rldLo <= '0;
      rldHi <= '0;
    end else begin
      if (strobe.wrRldLo) rldLo <= strobe.data;
      if (strobe.wrRldHi) rldHi <= strobe.data;
      if (wrCnt) begin
        if (strobe.wrLo) cntLo <= strobe.data;
        if (strobe.wrHi) cntHi <= strobe.data;
      end else if (step) begin
        if (strobe.split) begin
          cntLo <= loFull ? rldLo : cntLo + BYTE_W'(1);
          cntHi <= hiFull ? rldHi : cntHi + BYTE_W'(1);
        end else begin
          {cntHi, cntLo} <= (loFull && hiFull) ? {rldHi, rldLo}
                                               : {cntHi, cntLo} + CNT_W'(1);
        end
      end
    end
  end

  // R9: a counter write is taken as written, with no increment on top
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLo |=> count[BYTE_W-1:0] == $past(strobe.data));
  // R6: no pulse and no write means the count holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !wrCnt) |=> $stable(count));
  // R4: 16-bit overflow lands on the reload value
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (step && !strobe.split && count == '1) |=> count == $past(reload));
endmodule

// File: rtl/autoReloadTimer.sv
module autoReloadTimer
  import tmrPkg::*;
#(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              runEn,
  input  logic [1:0]        clkSel,
  input  logic              extClk,
  output logic              irq
);
  strobeT              strobe;
  logic                tick, wrapLo, wrapHi;
  logic [2*BYTE_W-1:0] count, reload;
  logic [BYTE_W-1:0]   ctrlByte;

  tmrPrescale #(.DIV_SYS(DIV_SYS), .DIV_EXT(DIV_EXT), .SYNC_N(SYNC_N)) uPre (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clkSel(clkSel),
    .extClk(extClk), .tick(tick)
  );

  tmrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .tickIn(tick), .wrapLo(wrapLo), .wrapHi(wrapHi),
    .strobe(strobe), .ctrlByte(ctrlByte), .irq(irq)
  );

  tmrDatapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count),
    .reload(reload), .wrapLo(wrapLo), .wrapHi(wrapHi)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CNT_LO: regRdData = count[BYTE_W-1:0];
      ADDR_CNT_HI: regRdData = count[2*BYTE_W-1:BYTE_W];
      ADDR_RLD_LO: regRdData = reload[BYTE_W-1:0];
      ADDR_RLD_HI: regRdData = reload[2*BYTE_W-1:BYTE_W];
      ADDR_CTRL:   regRdData = ctrlByte;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: tb/sim_autoReloadTimer.sv
module sim_autoReloadTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       runEn = 1'b0;
  logic [1:0] clkSel = 2'd0;
  logic       extClk = 1'b0;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  autoReloadTimer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .runEn(runEn),
    .clkSel(clkSel), .extClk(extClk), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rdCount(output logic [15:0] c);
    logic [7:0] lo, hi;
    rdReg(3'd0, lo);
    rdReg(3'd1, hi);
    c = {hi, lo};
  endtask

  task automatic setCount(input logic [15:0] c);
    wrReg(3'd0, c[7:0]);
    wrReg(3'd1, c[15:8]);
  endtask

  task automatic setReload(input logic [15:0] r);
    wrReg(3'd2, r[7:0]);
    wrReg(3'd3, r[15:8]);
  endtask

  task automatic runFor(input int n);
    @(negedge clk);
    runEn = 1'b1;
    repeat (n) @(negedge clk);
    runEn = 1'b0;
  endtask

  task automatic extEdges(input int k);
    repeat (k) begin
      extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // Reference model: returns {highFlag, lowFlag, count} after n count pulses
  function automatic logic [17:0] model(input logic [15:0] c, input logic [15:0] r,
                                        input int n, input bit split);
    logic lf = 1'b0, hf = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (split) begin
        if (c[7:0] == 8'hFF) begin c[7:0] = r[7:0]; lf = 1'b1; end
        else c[7:0] = c[7:0] + 8'd1;
        if (c[15:8] == 8'hFF) begin c[15:8] = r[15:8]; hf = 1'b1; end
        else c[15:8] = c[15:8] + 8'd1;
      end else begin
        if (c[7:0] == 8'hFF) lf = 1'b1;
        if (c == 16'hFFFF) begin c = r; hf = 1'b1; end
        else c = c + 16'd1;
      end
    end
    return {hf, lf, c};
  endfunction

  initial begin
    #4ms;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    logic [17:0] m;
    int          seed = 32'h1F2E3D4C;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rdReg(3'(a), d);
      check("R1 reset register", {8'h0, d}, 16'h0);
    end
    check("R1 reset irq", {15'h0, irq}, 16'h0);

    // R2: register readback
    setReload(16'hA55A);
    rdReg(3'd2, d); check("R2 reload low", {8'h0, d}, 16'h5A);
    rdReg(3'd3, d); check("R2 reload high", {8'h0, d}, 16'hA5);
    setCount(16'h12F0);
    rdCount(c); check("R2 counter readback", c, 16'h12F0);

    // R3: count every clock, carry into the high byte
    clkSel = 2'd0;
    runFor(32);
    rdCount(c); check("R3 count with carry", c, 16'h1310);

    // R6: runEn low holds
    repeat (10) @(negedge clk);
    rdCount(c); check("R6 hold while stopped", c, 16'h1310);

    // R4: 16-bit overflow reloads and sets both flags
    wrReg(3'd4, 8'h00);
    setCount(16'hFFFE);
    runFor(3);
    rdCount(c); check("R4 reload after overflow", c, 16'hA55B);
    rdReg(3'd4, d); check("R4 both flags set", {8'h0, d}, 16'h00C0);

    // R10: flags sticky, cleared by writing zero
    runFor(5);
    rdReg(3'd4, d); check("R10 flags sticky", {8'h0, d}, 16'h00C0);
    wrReg(3'd4, 8'h00);
    rdReg(3'd4, d); check("R10 flags cleared", {8'h0, d}, 16'h0000);

    // R5: low wrap only
    setCount(16'h00FE);
    runFor(3);
    rdCount(c); check("R5 low wrap carry", c, 16'h0101);
    rdReg(3'd4, d); check("R5 only low flag", {8'h0, d}, 16'h0040);

    // R11: interrupt combinations
    wrReg(3'd4, 8'h41); #1 check("R11 low flag without low enable", {15'h0, irq}, 16'h0);
    wrReg(3'd4, 8'h43); #1 check("R11 low flag with low enable", {15'h0, irq}, 16'h1);
    wrReg(3'd4, 8'h81); #1 check("R11 high flag enabled", {15'h0, irq}, 16'h1);
    wrReg(3'd4, 8'h82); #1 check("R11 global enable off", {15'h0, irq}, 16'h0);
    wrReg(3'd4, 8'h00);

    // R9: counter write beats a count pulse
    setCount(16'h12FF);
    @(negedge clk);
    runEn = 1'b1; regWrEn = 1'b1; regAddr = 3'd0; regWrData = 8'hFF;
    @(negedge clk);
    regWrEn = 1'b0; runEn = 1'b0; regAddr = 3'd1;
    #1 check("R9 no carry on write cycle", {8'h0, regRdData}, 16'h0012);
    rdReg(3'd0, d); check("R9 written low byte", {8'h0, d}, 16'h00FF);

    // R7: divide by 12
    setCount(16'h0000);
    clkSel = 2'd1;
    runFor(120);
    rdCount(c); check("R7 ten ticks in 120 cycles", c, 16'h000A);

    // R8: external divide by 8, and source 3 never counts
    setCount(16'h0000);
    clkSel = 2'd2;
    @(negedge clk); runEn = 1'b1;
    extEdges(24);
    repeat (8) @(negedge clk);
    runEn = 1'b0;
    rdCount(c); check("R8 three ticks from 24 edges", c, 16'h0003);
    clkSel = 2'd3;
    runFor(30);
    rdCount(c); check("R8 no source holds", c, 16'h0003);

    // R12: split mode
    clkSel = 2'd0;
    wrReg(3'd4, 8'h04);
    setReload(16'h3020);
    setCount(16'hFDFE);
    runFor(4);
    rdCount(c); check("R12 split bytes", c, 16'h3122);
    rdReg(3'd4, d); check("R12 split flags", {8'h0, d}, 16'h00C4);

    // Random runs against the model (R3 R4 R5 R12)
    for (int it = 0; it < 30; it++) begin
      logic [15:0] rs, cs;
      int          n;
      bit          sp;
      rs = 16'($urandom());
      cs = {8'hF0 | 8'($urandom()), 8'($urandom())};
      n  = 1 + int'($urandom() % 400);
      sp = 1'($urandom());
      wrReg(3'd4, {5'b0, sp, 2'b00});
      setReload(rs);
      setCount(cs);
      runFor(n);
      m = model(cs, rs, n, sp);
      rdCount(c); check("R4 random count", c, m[15:0]);
      rdReg(3'd4, d); check("R5 random flags", {14'h0, d[7:6]}, {14'h0, m[17:16]});
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule